// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

The block gathers up to sixteen interrupt request lines and picks one of them to hand to the CPU. Each line has its own enable bit and its own priority bit, and a global enable gates all of them. The winner is chosen in two steps. Requests at the high level beat requests at the low level. Among requests at the same level, the lowest source index wins. The controller registers the winner and presents it to the CPU as a request, a source index, a level and a vector address. Vector addresses are spaced eight bytes apart, starting at 0x0003.

The controller tracks nesting with one in-service flag per level. The flag for the winner's level is set when the CPU takes the call. A return-from-interrupt strobe clears the high flag if it is set, and otherwise clears the low flag. While a routine is in service, only a request at a strictly higher level can be presented. After a return, the controller withholds every request until the CPU reports that one further instruction has completed.

Clearing the pending flags at the peripherals is left to the peripherals and to software.

Top module: `intc_top`

## Requirements
- R1: While and after reset, irq_req_o is 0, irq_vec_o is 0x0000, irq_id_o is 0 and insv_o is 2'b00.
- R2: A source takes part in arbitration only when its pend_i, en_i and glb_en_i bits are all 1. A pending source whose enable is 0 produces no request, and its pending bit is not altered.
- R3: When requests at both levels are eligible, the high-level one wins, whatever its index. A prio_i bit of 1 means high and 0 means low.
- R4: Among eligible requests at the same level, the lowest source index wins.
- R5: Source index 8 is reserved. It is never presented, even when it is pending, enabled and set to high.
- R6: While irq_req_o is 1, irq_id_o carries the winning index, irq_lvl_o carries its level (1 means high), and irq_vec_o equals 0x0003 + 8·irq_id_o.
- R7: An eligible request sampled at a clock edge shows on irq_req_o right after that same edge, which is a one-cycle detection latency.
- R8: When call_ack_i is 1 while irq_req_o is 1, the in-service flag for irq_lvl_o is set (insv_o bit 1 for high, bit 0 for low), and irq_req_o is 0 after that edge.
- R9: With the high flag set, no request is presented. With only the low flag set, only high-level winners are presented, so a high request preempts a low routine.
- R10: A reti_i strobe clears insv_o bit 1 if it is set, and otherwise clears bit 0.
- R11: From a reti_i strobe until an insn_done_i strobe in a later cycle, no request is presented. A request may appear at the edge after that insn_done_i strobe.
- R12: When glb_en_i is 0, irq_req_o is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 16 | Pending flag for each source |
| en_i | input | 16 | Enable bit for each source |
| prio_i | input | 16 | Priority bit for each source (1 = high) |
| glb_en_i | input | 1 | Global interrupt enable |
| insn_done_i | input | 1 | Strobe: an instruction has completed |
| call_ack_i | input | 1 | Strobe: the CPU takes the presented call |
| reti_i | input | 1 | Strobe: a return-from-interrupt has executed |
| irq_req_o | output | 1 | A request is being presented |
| irq_id_o | output | 4 | Index of the presented source |
| irq_lvl_o | output | 1 | Level of the presented source (1 = high) |
| irq_vec_o | output | 16 | Vector address of the presented source |
| insv_o | output | 2 | In-service flags; bit 1 is high, bit 0 is low |

## Verification
The assertions are evaluated on every cycle and check the following:
- the vector formula and the exclusion of the reserved index;
- the nesting blocks: no request while the high level is in service, and only high requests while the low level is in service;
- the silence that follows a return and a disabled global enable;
- the setting of the high in-service flag when a call is taken.

Other behaviours depend on a sequence of stimulus and are shown only by the bench scenarios compared against the reference model. These are:
- the choice between several competing sources;
- preemption of a low routine, followed by two returns;
- the release of a request one cycle after the instruction that follows a return;
- a disabled source being ignored.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;
endpackage

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int N_SRC    = 16,
  parameter int RSVD_IDX = 8,
  localparam int IDW     = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             glb_en_i,
  output logic             vld_o,
  output intc_pkg::lvl_e   lvl_o,
  output logic [IDW-1:0]   id_o
);
  logic [N_SRC-1:0] cand, hi, sel;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cand
    if (g == RSVD_IDX) begin : g_rsvd
      assign cand[g] = 1'b0;
    end else begin : g_src
      assign cand[g] = pend_i[g] & en_i[g] & glb_en_i;
    end
  end

  assign hi    = cand & prio_i;
  assign sel   = (|hi) ? hi : cand;  // no high candidate: all candidates are low
  assign vld_o = |cand;
  assign lvl_o = (|hi) ? intc_pkg::LVL_HI : intc_pkg::LVL_LO;

  // lowest index wins
  always_comb begin
    id_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (sel[i]) id_o = IDW'(i);
    end
  end
endmodule

// File: rtl/intc_nest.sv
module intc_nest (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           take_i,
  input  intc_pkg::lvl_e take_lvl_i,
  input  logic           reti_i,
  input  logic           insn_done_i,
  output logic [1:0]     insv_o,
  output logic           hold_o
);
  logic [1:0] insv_d;

  always_comb begin
    insv_d = insv_o;
    if (reti_i) begin
      if (insv_o[1]) insv_d[1] = 1'b0;
      else           insv_d[0] = 1'b0;
    end
    if (take_i) insv_d[take_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insv_o <= 2'b00;
      hold_o <= 1'b0;
    end else begin
      insv_o <= insv_d;
      if (reti_i)           hold_o <= 1'b1;
      else if (insn_done_i) hold_o <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top #(
  parameter int N_SRC      = 16,
  parameter int RSVD_IDX   = 8,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int IDW       = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             glb_en_i,
  input  logic             insn_done_i,
  input  logic             call_ack_i,
  input  logic             reti_i,
  output logic             irq_req_o,
  output logic [IDW-1:0]   irq_id_o,
  output logic             irq_lvl_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic [1:0]       insv_o
);
  localparam logic [VEC_W-1:0] VBASE = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] VSTEP = VEC_W'(VEC_STRIDE);

  logic           arb_vld, hold, lvl_free, win_ok;
  intc_pkg::lvl_e arb_lvl, lvl_q;
  logic [IDW-1:0] arb_id;

  intc_arb #(.N_SRC(N_SRC), .RSVD_IDX(RSVD_IDX)) u_arb (
    .pend_i  (pend_i),
    .en_i    (en_i),
    .prio_i  (prio_i),
    .glb_en_i(glb_en_i),
    .vld_o   (arb_vld),
    .lvl_o   (arb_lvl),
    .id_o    (arb_id)
  );

  intc_nest u_nest (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (call_ack_i & irq_req_o),
    .take_lvl_i (lvl_q),
    .reti_i     (reti_i),
    .insn_done_i(insn_done_i),
    .insv_o     (insv_o),
    .hold_o     (hold)
  );

  // equal or higher level in service blocks
  assign lvl_free = (arb_lvl == intc_pkg::LVL_HI) ? ~insv_o[1] : ~|insv_o;
  assign win_ok   = arb_vld & lvl_free & ~hold & ~reti_i & ~call_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_req_o <= 1'b0;
      irq_id_o  <= '0;
      lvl_q     <= intc_pkg::LVL_LO;
      irq_vec_o <= '0;
    end else begin
      irq_req_o <= win_ok;
      if (win_ok) begin
        irq_id_o  <= arb_id;
        lvl_q     <= arb_lvl;
        irq_vec_o <= VBASE + VEC_W'(arb_id) * VSTEP;
      end
    end
  end

  assign irq_lvl_o = lvl_q;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int N_SRC      = 16,
  parameter int RSVD_IDX   = 8,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int IDW       = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glb_en_i,
  input logic             call_ack_i,
  input logic             reti_i,
  input logic             irq_req_o,
  input logic [IDW-1:0]   irq_id_o,
  input logic             irq_lvl_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [1:0]       insv_o
);
  AST_VEC_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> irq_vec_o == VEC_W'(VEC_BASE) + VEC_W'(irq_id_o) * VEC_W'(VEC_STRIDE)); // R6
  AST_NO_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> irq_id_o != IDW'(RSVD_IDX)); // R5
  AST_HI_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insv_o[1] |-> !irq_req_o); // R9
  AST_LO_ONLY_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insv_o[0] && irq_req_o) |-> irq_lvl_o); // R9
  AST_RETI_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> !irq_req_o); // R11
  AST_GLB_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> !irq_req_o); // R12
  AST_ACK_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_ack_i && irq_req_o && irq_lvl_o) |=> (insv_o[1] && !irq_req_o)); // R8
endmodule

bind intc_top intc_chk #(
  .N_SRC(N_SRC), .RSVD_IDX(RSVD_IDX), .VEC_W(VEC_W),
  .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .call_ack_i(call_ack_i),
  .reti_i(reti_i), .irq_req_o(irq_req_o), .irq_id_o(irq_id_o),
  .irq_lvl_o(irq_lvl_o), .irq_vec_o(irq_vec_o), .insv_o(insv_o)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] pend = '0, en = '0, prio = '0;
  logic        glb = 1'b0, insn = 1'b0, ack = 1'b0, reti = 1'b0;
  logic        req, lvl;
  logic [3:0]  id;
  logic [15:0] vec;
  logic [1:0]  insv;

  int checks = 0, errors = 0;
  string cur = "R1";

  // reference model state
  bit          m_req, m_lvl, m_hold, m_ok, w_lvl;
  int          m_id, w_id;
  logic [15:0] m_vec;
  bit [1:0]    m_ins;

  always #4 clk = ~clk;

  intc_top dut (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
    .glb_en_i(glb), .insn_done_i(insn), .call_ack_i(ack), .reti_i(reti),
    .irq_req_o(req), .irq_id_o(id), .irq_lvl_o(lvl), .irq_vec_o(vec), .insv_o(insv)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_lvl = 0; m_hold = 0; m_id = 0; m_vec = 0; m_ins = 0;
    end else begin
      w_id = -1; w_lvl = 0;
      for (int p = 1; p >= 0; p--)
        for (int i = 0; i < 16; i++)
          if (w_id < 0 && i != 8 && pend[i] && en[i] && glb && prio[i] == p[0]) begin
            w_id = i; w_lvl = p[0];
          end
      m_ok = (w_id >= 0) && !m_hold && !reti && !ack;
      if (m_ok) m_ok = w_lvl ? !m_ins[1] : (m_ins == 2'b00);
      if (reti) begin
        if (m_ins[1]) m_ins[1] = 0; else m_ins[0] = 0;
      end
      if (ack && m_req) m_ins[m_lvl] = 1;
      if (reti) m_hold = 1; else if (insn) m_hold = 0;
      if (m_ok) begin
        m_id = w_id; m_lvl = w_lvl; m_vec = 16'(3 + 8 * w_id);
      end
      m_req = m_ok;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(req == m_req, {cur, " req"}, req, m_req);
      chk(insv == m_ins, {cur, " insv"}, insv, m_ins);
      if (m_req) begin
        chk(id == m_id[3:0], {cur, " id"}, id, m_id);
        chk(lvl == m_lvl, {cur, " lvl"}, lvl, m_lvl);
        chk(vec == m_vec, {cur, " vec"}, vec, m_vec);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req == 0 && vec == 16'h0000 && id == 0 && insv == 0, "R1 reset", {vec, 3'b0, req}, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(req == 0, "R1 idle", req, 0);

    cur = "R2"; pend = 16'h0008; glb = 1; cyc(3);
    chk(req == 0, "R2 disabled ignored", req, 0);
    cur = "R7"; en = 16'hFFFF; cyc(1);
    chk(req == 1, "R7 one-cycle detect", req, 1);
    chk(vec == 16'h001B, "R6 vector id3", vec, 16'h001B);
    cur = "R12"; glb = 0; cyc(1);
    chk(req == 0, "R12 global off", req, 0);

    cur = "R5"; glb = 1; pend = 16'h0100; prio = 16'h0100; cyc(3);
    chk(req == 0, "R5 reserved", req, 0);

    cur = "R4"; prio = 16'h1000; pend = 16'h0024; cyc(2);
    chk(id == 2 && vec == 16'h0013, "R4 lowest index", id, 2);
    cur = "R3"; pend = 16'h1024; cyc(2);
    chk(id == 12 && lvl == 1 && vec == 16'h0063, "R3 high wins", id, 12);

    cur = "R8"; pend = 16'h0024; cyc(2);
    ack = 1; cyc(1); ack = 0;
    chk(req == 0 && insv == 2'b01, "R8 ack low", insv, 1);
    cur = "R9"; cyc(2);
    chk(req == 0, "R9 low blocked by low", req, 0);
    pend = 16'h1024; cyc(2);
    chk(req == 1 && id == 12, "R9 high preempts", id, 12);
    ack = 1; pend = 16'h0024; cyc(1); ack = 0;
    chk(insv == 2'b11, "R8 ack high", insv, 3);
    cyc(2);
    cur = "R10"; reti = 1; cyc(1); reti = 0;
    chk(insv == 2'b01, "R10 clear high first", insv, 1);
    cyc(2);
    chk(req == 0, "R9 low still blocked", req, 0);
    reti = 1; cyc(1); reti = 0;
    chk(insv == 2'b00, "R10 clear low", insv, 0);
    cur = "R11"; cyc(3);
    chk(req == 0, "R11 hold after return", req, 0);
    insn = 1; cyc(1); insn = 0;
    chk(req == 0, "R11 insn edge", req, 0);
    cyc(1);
    chk(req == 1 && id == 2, "R11 released", id, 2);
    cyc(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule